// File: doc/BRIEF.md
# Radio command strobe sequencer

This block is a small byte-coded micro-sequencer that issues radio control strobes. A host appends opcode bytes to a 24-byte local program store and then starts execution. The sequencer runs one instruction per clock. It keeps three 8-bit working registers (X, Y, Z) and a single loop label. It can stall on MAC-timer overflows or on either of two timer events. It can skip instructions or branch back to the label under a selectable, invertible condition. It also emits single-cycle command pulses toward the radio.

The host can also send immediate commands through the same byte bus. These commands fire a strobe at once, start or stop the program, or wipe the program store, and they do not move the program counter. The radio front end, the data FIFOs and the timer are outside the block. Only their status bits and event pulses enter it.

Top module: `strobe_seq`

## Requirements
- R1: After reset, strobe_o, irq_o, running_o, done_o, pc_o, x_o, y_o and z_o are all zero.
- R2: An immediate command 0xEk, with k in {3..11, 13, 14, 15}, raises strobe_o[k] for exactly the one cycle after it is captured, whether or not a program is running, and leaves pc_o unchanged. For 0xE0, 0xEC and 0xEk with k in {1, 2}, no strobe bit rises. strobe_o[0], [1], [2] and [12] never rise.
- R3: Immediate 0xE1 sets running_o, clears done_o and sets pc_o to 0 in the next cycle. Immediate 0xE2 clears running_o and keeps pc_o.
- R4: While running, one instruction executes per cycle. Program opcode 0xDk, with k in the R2 set, raises strobe_o[k] for the cycle after it executes. 0xD0 and 0xDC raise nothing.
- R5: 0xC0, 0xC1 and 0xC2 add one to X, Y and Z. 0xC3, 0xC4 and 0xC5 subtract one. All wrap modulo 256. While running_o is low, the registers do not change.
- R6: 0xC8|M, with M in bits 2:0, sets Y to M when Y >= M, and to Y+1 otherwise.
- R7: 0x80|W, with W in bits 4:0, stalls until W overflow pulses have been captured. 0xBC stalls for X pulses. A count of 0 does not stall. After the last pulse is captured, the next instruction executes on the following clock.
- R8: 0xB8 stalls until tmr_evt1 is captured, and 0xB9 until tmr_evt2. The other event has no effect on the stall.
- R9: 0xBB stores the address after itself as the label. 0xA0|N<<3|C jumps to the label when condition C XOR N holds, and otherwise falls through.
- R10: A skip byte 0|S<<4|N<<3|C (bit 7 clear, S in bits 6:4) jumps over the next S instructions when condition C XOR N holds. Conditions 0 to 7 are: cca, sfd, host_flag, tmr_cmp, Z==0, X==0, Y==0, rssi_valid.
- R11: 0xBD loads rnd_in into X. 0xBA raises irq_o for the cycle after it executes.
- R12: If 0xD2 executes, or the program counter is at or past the number of stored bytes, running_o clears and done_o sets. done_o stays set until a start or a clear command.
- R13: Immediate 0xFF empties the program store, sets pc_o to 0 and clears running_o and done_o. prog_we appends host_op to the store, and writes beyond 24 bytes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_op | input | 8 | Opcode byte from the host |
| prog_we | input | 1 | Append host_op to the program store |
| cmd_we | input | 1 | Execute host_op as an immediate command |
| tmr_ovf | input | 1 | MAC-timer overflow pulse |
| tmr_evt1 | input | 1 | Timer event 1 pulse |
| tmr_evt2 | input | 1 | Timer event 2 pulse |
| rnd_in | input | 8 | Random byte source |
| cca | input | 1 | Clear-channel status (condition 0) |
| sfd | input | 1 | Frame-delimiter status (condition 1) |
| host_flag | input | 1 | Host control flag (condition 2) |
| tmr_cmp | input | 1 | Timer compare status (condition 3) |
| rssi_valid | input | 1 | Signal-strength valid (condition 7) |
| strobe_o | output | 16 | Radio command pulses, bit k for code k |
| irq_o | output | 1 | Interrupt pulse |
| running_o | output | 1 | Program executing |
| done_o | output | 1 | Program finished |
| pc_o | output | 5 | Program counter |
| x_o | output | 8 | Register X |
| y_o | output | 8 | Register Y |
| z_o | output | 8 | Register Z |

## Verification
Every result is registered once. An immediate strobe, start, stop or clear is visible in the cycle right after the capturing edge. The first program instruction takes effect one cycle after the start command, and each later instruction one cycle after the one before it. A wait releases on the edge that captures the final overflow or event, so the next instruction shows a further cycle later. The bench drives and samples on falling edges. It steps exactly that many cycles before each compare, and it also checks the cycle just before a due result to catch early firing.

// File: rtl/strobe_seq_pkg.sv
package strobe_seq_pkg;

  localparam int STROBE_W = 16;

  localparam logic [7:0] IMM_START = 8'hE1;
  localparam logic [7:0] IMM_STOP  = 8'hE2;
  localparam logic [7:0] IMM_CLEAR = 8'hFF;

  typedef enum logic [3:0] {
    K_NOP, K_SKIP, K_WAITW, K_RPT, K_WEV1, K_WEV2, K_INT, K_LABEL,
    K_WAITX, K_RAND, K_INCDEC, K_INCMAX, K_STOP, K_STROBE
  } op_kind_e;

  typedef struct packed {
    op_kind_e    kind;
    logic [4:0]  cnt;   // wait count or skip distance
    logic        inv;
    logic [2:0]  csel;
    logic [1:0]  rsel;  // 0 X, 1 Y, 2 Z
    logic        dec;
    logic [2:0]  ymax;
    logic [3:0]  nib;   // strobe index
  } op_dec_t;

  typedef enum logic [1:0] { WS_RUN, WS_OVF, WS_EV1, WS_EV2 } wait_e;

  function automatic logic nib_is_strobe(input logic [3:0] n);
    return (n >= 4'd3) && (n != 4'hC);
  endfunction

endpackage

// File: rtl/seq_progmem.sv
module seq_progmem #(
  parameter int DEPTH = 24,
  parameter int AW    = 5,
  parameter int LW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  input  logic          clr,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic [LW-1:0] len
);

  logic [7:0] mem_q [DEPTH];
  logic       room;

  assign room = (len < LW'(DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                len <= '0;
    else if (clr)              len <= '0;
    else if (wr_en && room)    len <= len + LW'(1);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit;
    assign hit = wr_en && (len == LW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q[i] <= '0;
      else if (clr)   mem_q[i] <= '0;
      else if (hit)   mem_q[i] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_addr == AW'(i)) rd_data = mem_q[i];
  end

endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import strobe_seq_pkg::*;
(
  input  logic [7:0] op,
  output op_dec_t    d
);

  always_comb begin
    d      = '0;
    d.kind = K_NOP;
    if (!op[7]) begin
      d.kind = K_SKIP;
      d.cnt  = {2'b00, op[6:4]};
      d.inv  = op[3];
      d.csel = op[2:0];
    end else if (op[7:5] == 3'b100) begin
      d.kind = K_WAITW;
      d.cnt  = op[4:0];
    end else if (op[7:4] == 4'hA) begin
      d.kind = K_RPT;
      d.inv  = op[3];
      d.csel = op[2:0];
    end else if (op[7:3] == 5'b11001) begin
      d.kind = K_INCMAX;
      d.ymax = op[2:0];
    end else if (op[7:4] == 4'hD) begin
      if (op[3:0] == 4'h2) d.kind = K_STOP;
      else if (nib_is_strobe(op[3:0])) begin
        d.kind = K_STROBE;
        d.nib  = op[3:0];
      end
    end else begin
      case (op)
        8'hB8: d.kind = K_WEV1;
        8'hB9: d.kind = K_WEV2;
        8'hBA: d.kind = K_INT;
        8'hBB: d.kind = K_LABEL;
        8'hBC: d.kind = K_WAITX;
        8'hBD: d.kind = K_RAND;
        8'hC0: begin d.kind = K_INCDEC; d.rsel = 2'd0; end
        8'hC1: begin d.kind = K_INCDEC; d.rsel = 2'd1; end
        8'hC2: begin d.kind = K_INCDEC; d.rsel = 2'd2; end
        8'hC3: begin d.kind = K_INCDEC; d.rsel = 2'd0; d.dec = 1'b1; end
        8'hC4: begin d.kind = K_INCDEC; d.rsel = 2'd1; d.dec = 1'b1; end
        8'hC5: begin d.kind = K_INCDEC; d.rsel = 2'd2; d.dec = 1'b1; end
        default: d.kind = K_NOP;
      endcase
    end
  end

endmodule

// File: rtl/seq_cond.sv
module seq_cond (
  input  logic [2:0] sel,
  input  logic       inv,
  input  logic       cca,
  input  logic       sfd,
  input  logic       host_flag,
  input  logic       tmr_cmp,
  input  logic       rssi_valid,
  input  logic [7:0] x,
  input  logic [7:0] y,
  input  logic [7:0] z,
  output logic       taken
);

  logic [7:0] src;

  assign src   = {rssi_valid, (y == 8'd0), (x == 8'd0), (z == 8'd0),
                  tmr_cmp, host_flag, sfd, cca};
  assign taken = src[sel] ^ inv;

endmodule

// File: rtl/strobe_seq.sv
module strobe_seq
  import strobe_seq_pkg::*;
#(
  parameter  int PROG_DEPTH = 24,
  localparam int PCW        = $clog2(PROG_DEPTH + 8),
  localparam int LW         = $clog2(PROG_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [7:0]          host_op,
  input  logic                prog_we,
  input  logic                cmd_we,
  input  logic                tmr_ovf,
  input  logic                tmr_evt1,
  input  logic                tmr_evt2,
  input  logic [7:0]          rnd_in,
  input  logic                cca,
  input  logic                sfd,
  input  logic                host_flag,
  input  logic                tmr_cmp,
  input  logic                rssi_valid,
  output logic [STROBE_W-1:0] strobe_o,
  output logic                irq_o,
  output logic                running_o,
  output logic                done_o,
  output logic [PCW-1:0]      pc_o,
  output logic [7:0]          x_o,
  output logic [7:0]          y_o,
  output logic [7:0]          z_o
);

  logic [PCW-1:0]      pc_q, pc_d, lbl_q, lbl_d, pc_inc;
  logic                run_q, run_d, done_q, done_d, irq_q, irq_d;
  logic [7:0]          x_q, x_d, y_q, y_d, z_q, z_d, wc_q, wc_d;
  wait_e               ws_q, ws_d;
  logic [STROBE_W-1:0] stb_q, stb_d;
  logic [7:0]          mem_rd;
  logic [LW-1:0]       prog_len;
  op_dec_t             dec;
  logic                cond_hit, at_end, mem_clr;

  assign mem_clr = cmd_we && (host_op == IMM_CLEAR);

  seq_progmem #(.DEPTH(PROG_DEPTH), .AW(PCW), .LW(LW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(prog_we), .wr_data(host_op),
    .clr(mem_clr), .rd_addr(pc_q), .rd_data(mem_rd), .len(prog_len)
  );

  seq_decode u_dec (.op(mem_rd), .d(dec));

  seq_cond u_cond (
    .sel(dec.csel), .inv(dec.inv), .cca(cca), .sfd(sfd),
    .host_flag(host_flag), .tmr_cmp(tmr_cmp), .rssi_valid(rssi_valid),
    .x(x_q), .y(y_q), .z(z_q), .taken(cond_hit)
  );

  assign at_end = (pc_q >= PCW'(prog_len));
  assign pc_inc = pc_q + PCW'(1);

  // next-state logic
  always_comb begin
    pc_d   = pc_q;   run_d = run_q;  done_d = done_q;
    x_d    = x_q;    y_d   = y_q;    z_d    = z_q;
    lbl_d  = lbl_q;  ws_d  = ws_q;   wc_d   = wc_q;
    stb_d  = '0;     irq_d = 1'b0;

    if (run_q) begin
      case (ws_q)
        WS_OVF: if (tmr_ovf) begin
          wc_d = wc_q - 8'd1;
          if (wc_q == 8'd1) ws_d = WS_RUN;
        end
        WS_EV1: if (tmr_evt1) ws_d = WS_RUN;
        WS_EV2: if (tmr_evt2) ws_d = WS_RUN;
        default: begin
          if (at_end) begin
            run_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            pc_d = pc_inc;
            case (dec.kind)
              K_SKIP:  if (cond_hit) pc_d = pc_inc + PCW'(dec.cnt[2:0]);
              K_RPT:   if (cond_hit) pc_d = lbl_q;
              K_LABEL: lbl_d = pc_inc;
              K_WAITW: if (dec.cnt != 5'd0) begin
                ws_d = WS_OVF;
                wc_d = {3'b000, dec.cnt};
              end
              K_WAITX: if (x_q != 8'd0) begin
                ws_d = WS_OVF;
                wc_d = x_q;
              end
              K_WEV1:  ws_d = WS_EV1;
              K_WEV2:  ws_d = WS_EV2;
              K_INT:   irq_d = 1'b1;
              K_RAND:  x_d = rnd_in;
              K_INCDEC: begin
                case (dec.rsel)
                  2'd0:    x_d = dec.dec ? x_q - 8'd1 : x_q + 8'd1;
                  2'd1:    y_d = dec.dec ? y_q - 8'd1 : y_q + 8'd1;
                  default: z_d = dec.dec ? z_q - 8'd1 : z_q + 8'd1;
                endcase
              end
              K_INCMAX: y_d = (y_q >= {5'd0, dec.ymax}) ? {5'd0, dec.ymax} : y_q + 8'd1;
              K_STOP: begin
                run_d  = 1'b0;
                done_d = 1'b1;
              end
              K_STROBE: stb_d[dec.nib] = 1'b1;
              default: ;
            endcase
          end
        end
      endcase
    end

    // host immediate path, independent of the program counter
    if (cmd_we) begin
      if ((host_op[7:4] == 4'hE) && nib_is_strobe(host_op[3:0]))
        stb_d[host_op[3:0]] = 1'b1;
      if (host_op == IMM_START) begin
        run_d = 1'b1; pc_d = '0; done_d = 1'b0; ws_d = WS_RUN; wc_d = '0;
      end else if (host_op == IMM_STOP) begin
        run_d = 1'b0; ws_d = WS_RUN;
      end else if (host_op == IMM_CLEAR) begin
        run_d = 1'b0; pc_d = '0; done_d = 1'b0; ws_d = WS_RUN; wc_d = '0;
      end
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;  lbl_q <= '0;  run_q <= 1'b0; done_q <= 1'b0;
      x_q   <= '0;  y_q   <= '0;  z_q   <= '0;   wc_q   <= '0;
      ws_q  <= WS_RUN; stb_q <= '0; irq_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;  lbl_q <= lbl_d; run_q <= run_d; done_q <= done_d;
      x_q   <= x_d;   y_q   <= y_d;   z_q   <= z_d;   wc_q   <= wc_d;
      ws_q  <= ws_d;  stb_q <= stb_d; irq_q <= irq_d;
    end
  end

  assign strobe_o  = stb_q;
  assign irq_o     = irq_q;
  assign running_o = run_q;
  assign done_o    = done_q;
  assign pc_o      = pc_q;
  assign x_o       = x_q;
  assign y_o       = y_q;
  assign z_o       = z_q;

endmodule

// File: rtl/strobe_seq_chk.sv
module strobe_seq_chk #(
  parameter int PCW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [7:0]     host_op,
  input logic           cmd_we,
  input logic [15:0]    strobe_o,
  input logic           irq_o,
  input logic           running_o,
  input logic           done_o,
  input logic [PCW-1:0] pc_o,
  input logic [7:0]     x_o,
  input logic [7:0]     y_o,
  input logic [7:0]     z_o
);

  p_imm_rxon_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && host_op == 8'hE3) |=> strobe_o[3]);

  p_dead_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe_o[0] && !strobe_o[1] && !strobe_o[2] && !strobe_o[12]);

  p_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && host_op == 8'hE1) |=> (running_o && pc_o == '0 && !done_o));

  p_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && host_op == 8'hE2) |=> !running_o);

  p_regs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !running_o |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(running_o));

  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !running_o);

  p_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && host_op == 8'hFF) |=> (pc_o == '0 && !running_o && !done_o));

endmodule

bind strobe_seq strobe_seq_chk #(.PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_op(host_op), .cmd_we(cmd_we),
  .strobe_o(strobe_o), .irq_o(irq_o), .running_o(running_o),
  .done_o(done_o), .pc_o(pc_o), .x_o(x_o), .y_o(y_o), .z_o(z_o)
);

// File: tb/strobe_seq_tb_top.sv
module strobe_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  host_op;
  logic        prog_we, cmd_we, tmr_ovf, tmr_evt1, tmr_evt2;
  logic [7:0]  rnd_in;
  logic        cca, sfd, host_flag, tmr_cmp, rssi_valid;
  logic [15:0] strobe_o;
  logic        irq_o, running_o, done_o;
  logic [4:0]  pc_o;
  logic [7:0]  x_o, y_o, z_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] prg [32];

  always #2 clk = ~clk;

  strobe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .host_op(host_op), .prog_we(prog_we),
    .cmd_we(cmd_we), .tmr_ovf(tmr_ovf), .tmr_evt1(tmr_evt1),
    .tmr_evt2(tmr_evt2), .rnd_in(rnd_in), .cca(cca), .sfd(sfd),
    .host_flag(host_flag), .tmr_cmp(tmr_cmp), .rssi_valid(rssi_valid),
    .strobe_o(strobe_o), .irq_o(irq_o), .running_o(running_o),
    .done_o(done_o), .pc_o(pc_o), .x_o(x_o), .y_o(y_o), .z_o(z_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // caller sits on a falling edge; input is captured by the next rising edge
  task automatic issue(input logic [7:0] op, input bit to_prog);
    host_op = op;
    if (to_prog) prog_we = 1'b1; else cmd_we = 1'b1;
    @(negedge clk);
    prog_we = 1'b0;
    cmd_we  = 1'b0;
  endtask

  task automatic pulse_ovf();
    tmr_ovf = 1'b1; @(negedge clk); tmr_ovf = 1'b0;
  endtask

  task automatic load_run(input int n);
    issue(8'hFF, 1'b0);
    for (int i = 0; i < n; i++) issue(prg[i], 1'b1);
    issue(8'hE1, 1'b0);
  endtask

  function automatic logic [31:0] imm_exp(input logic [3:0] nib);
    return ((nib >= 4'd3) && (nib != 4'hC)) ? (32'd1 << nib) : 32'd0;
  endfunction

  function automatic logic [23:0] reg_model(input logic [23:0] s,
                                            input logic [7:0] op,
                                            input logic [7:0] rnd);
    logic [7:0] x, y, z;
    {x, y, z} = s;
    case (op)
      8'hC0: x = x + 8'd1;
      8'hC1: y = y + 8'd1;
      8'hC2: z = z + 8'd1;
      8'hC3: x = x - 8'd1;
      8'hC4: y = y - 8'd1;
      8'hC5: z = z - 8'd1;
      8'hBD: x = rnd;
      default: if (op[7:3] == 5'b11001)
                 y = (y >= {5'd0, op[2:0]}) ? {5'd0, op[2:0]} : y + 8'd1;
    endcase
    return {x, y, z};
  endfunction

  function automatic logic cond_model(input logic [2:0] sel);
    case (sel)
      3'd0: return cca;
      3'd1: return sfd;
      3'd2: return host_flag;
      3'd3: return tmr_cmp;
      3'd4: return z_o == 8'd0;
      3'd5: return x_o == 8'd0;
      3'd6: return y_o == 8'd0;
      default: return rssi_valid;
    endcase
  endfunction

  task automatic finish_run();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [23:0] st;
    int steps;
    bit seen;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; host_op = '0; prog_we = 0; cmd_we = 0;
    tmr_ovf = 0; tmr_evt1 = 0; tmr_evt2 = 0; rnd_in = '0;
    cca = 0; sfd = 0; host_flag = 0; tmr_cmp = 0; rssi_valid = 0;
    repeat (3) @(negedge clk);
    chk("R1", "strobe", 32'(strobe_o), 0);
    chk("R1", "flags", {irq_o, running_o, done_o}, 0);
    chk("R1", "pc", 32'(pc_o), 0);
    chk("R1", "xyz", {x_o, y_o, z_o}, 0);
    rst_n = 1'b1;
    step();

    // R2: random immediate strobes while idle
    for (int i = 0; i < 40; i++) begin
      logic [3:0] nib;
      do nib = 4'($urandom); while (nib == 4'd1 || nib == 4'd2);
      issue({4'hE, nib}, 1'b0);
      chk("R2", "imm strobe", 32'(strobe_o), imm_exp(nib));
      chk("R2", "imm pc", 32'(pc_o), 0);
      if (i % 4 == 0) begin
        step();
        chk("R2", "pulse end", 32'(strobe_o), 0);
      end
    end

    // R4, R12: program strobes, one per cycle, ended by stop
    prg[0] = 8'hD3; prg[1] = 8'hD9; prg[2] = 8'hDF; prg[3] = 8'hD0;
    prg[4] = 8'hDC; prg[5] = 8'hD2;
    load_run(6);
    chk("R3", "start", {running_o, done_o, 3'b0, pc_o}, {1'b1, 1'b0, 8'h0});
    step(); chk("R4", "D3", 32'(strobe_o), 32'h8);
    step(); chk("R4", "D9", 32'(strobe_o), 32'h200);
    step(); chk("R4", "DF", 32'(strobe_o), 32'h8000);
    step(); chk("R4", "D0", 32'(strobe_o), 0);
    step(); chk("R4", "DC", 32'(strobe_o), 0);
            chk("R12", "not yet done", 32'(done_o), 0);
    step(); chk("R12", "stop", {running_o, done_o}, 2'b01);

    // R5, R6, R11: random register programs against a bench model
    for (int it = 0; it < 16; it++) begin
      int n;
      n = 1 + int'($urandom % 24);
      rnd_in = 8'($urandom);
      st = {x_o, y_o, z_o};
      for (int i = 0; i < n; i++) begin
        int r;
        r = int'($urandom % 8);
        if (r < 6)       prg[i] = 8'hC0 + 8'(r);
        else if (r == 6) prg[i] = 8'hC8 | 8'($urandom % 8);
        else             prg[i] = 8'hBD;
        st = reg_model(st, prg[i], rnd_in);
      end
      load_run(n);
      steps = 0;
      while (!done_o && steps < 40) begin step(); steps++; end
      chk("R12", "end steps", steps, n + 1);
      chk("R5", "xyz R6 R11", {x_o, y_o, z_o}, st);
    end

    // R7: overflow wait of three
    prg[0] = 8'h83; prg[1] = 8'hD3; prg[2] = 8'hD2;
    load_run(3);
    step(); chk("R7", "stalled", 32'(strobe_o), 0);
    pulse_ovf(); chk("R7", "ovf1", 32'(strobe_o), 0);
    pulse_ovf(); chk("R7", "ovf2 pc", 32'(pc_o), 1);
    pulse_ovf(); chk("R7", "ovf3", 32'(strobe_o), 0);
    step();      chk("R7", "released", 32'(strobe_o), 32'h8);

    // R7: zero count does not stall
    prg[0] = 8'h80; prg[1] = 8'hD3; prg[2] = 8'hD2;
    load_run(3);
    step(); step(); chk("R7", "W=0", 32'(strobe_o), 32'h8);

    // R7, R11: wait for X overflows after random load
    rnd_in = 8'd2;
    prg[0] = 8'hBD; prg[1] = 8'hBC; prg[2] = 8'hD3; prg[3] = 8'hD2;
    load_run(4);
    step(); chk("R11", "rand x", 32'(x_o), 2);
    step();
    pulse_ovf(); chk("R7", "x wait", 32'(strobe_o), 0);
    pulse_ovf(); chk("R7", "x wait end", 32'(strobe_o), 0);
    step();      chk("R7", "x released", 32'(strobe_o), 32'h8);

    // R8: event 1 wait ignores event 2
    prg[0] = 8'hB8; prg[1] = 8'hD3; prg[2] = 8'hD2;
    load_run(3);
    step();
    tmr_evt2 = 1'b1; step(); tmr_evt2 = 1'b0;
    step(); chk("R8", "evt2 ignored", {running_o, strobe_o}, {1'b1, 16'h0});
    tmr_evt1 = 1'b1; step(); tmr_evt1 = 1'b0;
    chk("R8", "evt1 edge", 32'(strobe_o), 0);
    step(); chk("R8", "evt1 release", 32'(strobe_o), 32'h8);

    // R9: countdown loop of three
    rnd_in = 8'd3;
    prg[0] = 8'hBD; prg[1] = 8'hBB; prg[2] = 8'hC3; prg[3] = 8'hAD; prg[4] = 8'hD2;
    load_run(5);
    repeat (8) step();
    chk("R9", "loop busy", 32'(done_o), 0);
    step();
    chk("R9", "loop done", {done_o, x_o}, {1'b1, 8'h0});

    // R10: directed skips on cca
    prg[0] = 8'h20; prg[1] = 8'hD3; prg[2] = 8'hD9; prg[3] = 8'hDF; prg[4] = 8'hD2;
    cca = 1'b1; load_run(5); step(); step();
    chk("R10", "skip2 taken", 32'(strobe_o), 32'h8000);
    cca = 1'b0; load_run(5); step(); step();
    chk("R10", "skip2 not", 32'(strobe_o), 32'h8);
    prg[0] = 8'h28; cca = 1'b1; load_run(5); step(); step();
    chk("R10", "inverted", 32'(strobe_o), 32'h8);

    // R10: random conditions, skip one
    for (int it = 0; it < 16; it++) begin
      logic [2:0] sel;
      logic inv, exp_t;
      sel = 3'($urandom); inv = 1'($urandom);
      {cca, sfd, host_flag, tmr_cmp, rssi_valid} = 5'($urandom);
      prg[0] = {1'b0, 3'd1, inv, sel}; prg[1] = 8'hD3; prg[2] = 8'hD9; prg[3] = 8'hD2;
      exp_t = cond_model(sel) ^ inv;
      load_run(4); step(); step();
      chk("R10", "random cond", 32'(strobe_o), exp_t ? 32'h200 : 32'h8);
    end

    // R10, R12: skip past end
    cca = 1'b1; prg[0] = 8'h70;
    load_run(1); step();
    chk("R12", "after skip", 32'(done_o), 0);
    step(); chk("R12", "end by skip", {running_o, done_o}, 2'b01);

    // R11: interrupt
    prg[0] = 8'hBA; prg[1] = 8'hD2;
    load_run(2);
    chk("R11", "irq quiet", 32'(irq_o), 0);
    step(); chk("R11", "irq", 32'(irq_o), 1);
    step(); chk("R11", "irq end", {irq_o, done_o}, 2'b01);

    // R2, R3: immediate command during a stalled program, then stop
    prg[0] = 8'hB9; prg[1] = 8'hD2;
    load_run(2); step();
    issue(8'hE9, 1'b0);
    chk("R2", "imm while run", {running_o, 3'b0, pc_o, strobe_o}, {1'b1, 8'h01, 16'h200});
    issue(8'hE2, 1'b0);
    chk("R3", "stop keeps pc", {running_o, 3'b0, pc_o}, {1'b0, 8'h01});
    st = {x_o, y_o, z_o};
    repeat (3) step();
    chk("R5", "idle regs", {x_o, y_o, z_o}, st);

    // R13: clear then start runs an empty program
    issue(8'hFF, 1'b0);
    chk("R13", "clear", {running_o, done_o, 3'b0, pc_o}, 0);
    issue(8'hE1, 1'b0);
    step(); chk("R13", "empty done", {running_o, done_o}, 2'b01);

    // R13: writes past capacity are dropped
    issue(8'hFF, 1'b0);
    for (int i = 0; i < 24; i++) issue(8'hC0, 1'b1);
    issue(8'hD9, 1'b1); issue(8'hD9, 1'b1);
    st = {x_o, y_o, z_o};
    issue(8'hE1, 1'b0);
    steps = 0; seen = 0;
    while (!done_o && steps < 40) begin
      step(); steps++;
      if (strobe_o[9]) seen = 1;
    end
    chk("R13", "full steps", steps, 25);
    chk("R13", "dropped", {7'd0, seen, x_o}, {8'd0, st[23:16] + 8'd24});

    finish_run();
  end

endmodule